// File: doc/BRIEF.md
# ROM Entry List Walker

This block parses the chain of variable-length records that follows a fixed 22-byte header in a byte-addressed configuration ROM. After a start pulse it fetches bytes through a plain synchronous read port: it drives an address with a read enable, and the byte comes back on the following cycle. The first byte of each entry gives that entry's length, and the entry after it begins that many bytes later. The walk stops when the position reaches the total size that was captured at start.

For each entry typed as a port, the walker emits a one-cycle record. The record carries the port index and the disabled flag. For an enabled port it also carries the link number and, if the entry names one, the dual-link partner port. Generic entries are stepped over. A malformed chain ends the walk with an error pulse and a code. An overrun code covers three cases: a zero length, an entry that runs past the end, and a position that leaves room for only one byte. A length code covers an enabled port entry whose length is not 8. A clean walk ends with a done pulse.

Top module: `rom_entry_walker`

## Requirements
- R1: After reset, busy, rec_valid, walk_done and walk_err are all 0.
- R2: A start pulse while idle captures rom_size and begins the walk at position 22, so the first read issued is to address 22 (provided 22 < rom_size).
- R3: When the position is at or beyond the captured size, the walk ends with a one-cycle walk_done and no error; a size of 22 or less gives walk_done with no records.
- R4: An entry whose byte 1 bit 7 is 0 (generic) produces no record, and the walk moves on by its length.
- R5: A port entry (byte 1 bit 7 = 1) with byte 1 bit 6 = 1 gives a record with rec_port = byte 1 bits 5:0 and rec_disabled = 1, with rec_link, rec_has_dual and rec_dual_port all 0. Any non-zero length is accepted.
- R6: An enabled port entry of length 8 gives a record with rec_disabled = 0, rec_link = byte 2 bit 4 and rec_has_dual = byte 2 bit 7. rec_dual_port is byte 3 bits 5:0 when rec_has_dual is 1, and 0 otherwise. The remaining bits and bytes are ignored.
- R7: An entry with length 0 ends the walk with walk_err and err_code = 1 (overrun).
- R8: If the entry position plus 1 equals the size, the walk ends with err_code = 1.
- R9: If the entry position plus its length exceeds the size, the walk ends with err_code = 1, and no read is ever issued at or beyond the captured size.
- R10: An enabled port entry whose length is not 8 ends the walk with err_code = 2 (length).
- R11: Each walk ends with exactly one single-cycle pulse of walk_done or walk_err, never both, and busy is 0 in that cycle. rec_valid is a single-cycle pulse.
- R12: A start pulse or a rom_size change while busy has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| rom_size | input | 11 | Total ROM image size in bytes |
| rd_en | output | 1 | ROM read request |
| rd_addr | output | 11 | ROM read byte address |
| rd_data | input | 8 | ROM byte, valid one cycle after the request |
| busy | output | 1 | Walk in progress |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_port | output | 6 | Port index of the record |
| rec_disabled | output | 1 | Port marked disabled |
| rec_link | output | 1 | Link number |
| rec_has_dual | output | 1 | Dual-link partner present |
| rec_dual_port | output | 6 | Dual-link partner port index |
| walk_done | output | 1 | One-cycle clean-end pulse |
| walk_err | output | 1 | One-cycle error-end pulse |
| err_code | output | 2 | 1 = overrun, 2 = length; valid with walk_err |

## Verification
The hardest case to reach from the ports is an entry that starts at the last byte of the image. Only the position-plus-one rule catches it, because a length of 1 there would pass the bounds check. The stimulus places a 2-byte generic entry at 22, puts a length byte of 1 at 24 and sets the size to 25. The other error rules are reached with chains built byte by byte: a valid port record comes first and a zero-length entry follows, which shows that records made before an abort are still emitted. A start pulse and a size change applied mid-walk show that the walk captures its size once.

// File: rtl/rom_walk_pkg.sv
// Shared types and codes for the ROM entry list walker.
// Assumes byte-wide ROM data; positions are ADDR_W bits in the top module.
package rom_walk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LEN,
        ST_HDR,
        ST_LINK,
        ST_PEER
    } walk_state_t;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_OVERRUN = 2'd1;
    localparam logic [1:0] ERR_LENGTH  = 2'd2;

    localparam int IDX_W = 6;

    typedef struct packed {
        logic [IDX_W-1:0] port;
        logic             disabled;
        logic             link;
        logic             has_dual;
        logic [IDX_W-1:0] dual_port;
    } port_rec_t;
endpackage

// File: rtl/entry_guard.sv
// Bounds check for one entry: flags an overrun when the length is zero,
// when only one byte remains at the position, or when the entry would
// run past the end. Assumes pos < size on entry (checked by the caller).
module entry_guard #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] pos,
    input  logic [ADDR_W-1:0] size,
    input  logic [7:0]        len,
    output logic              overrun
);
    logic [ADDR_W:0] end_pos;
    logic [ADDR_W:0] next_pos;

    // Extended-width sums so the comparisons cannot wrap.
    always_comb begin
        end_pos  = {1'b0, pos} + (ADDR_W+1)'(len);
        next_pos = {1'b0, pos} + (ADDR_W+1)'(1);
        overrun  = (len == 8'd0) || (next_pos == {1'b0, size}) ||
                   (end_pos > {1'b0, size});
    end
endmodule

// File: rtl/port_field_decode.sv
// Splits the header, link and peer bytes of an entry into record fields.
// Assumes the three bytes are presented together; fields of a disabled
// port are forced to zero, and the partner index is zero without a partner.
module port_field_decode
    import rom_walk_pkg::*;
(
    input  logic [7:0] hdr_byte,
    input  logic [7:0] link_byte,
    input  logic [7:0] peer_byte,
    output logic       is_port,
    output port_rec_t  rec
);
    // Field extraction by bit position within each byte.
    always_comb begin
        is_port       = hdr_byte[7];
        rec.port      = hdr_byte[IDX_W-1:0];
        rec.disabled  = hdr_byte[6];
        rec.link      = hdr_byte[6] ? 1'b0 : link_byte[4];
        rec.has_dual  = hdr_byte[6] ? 1'b0 : link_byte[7];
        rec.dual_port = rec.has_dual ? peer_byte[IDX_W-1:0] : '0;
    end
endmodule

// File: rtl/rom_entry_walker.sv
// Walks the entry chain after a fixed header in a ROM image read through a
// one-cycle-latency port, emitting one record per port entry and ending
// with a done pulse or an error pulse with a code.
// Assumes the ROM returns rd_data on the cycle after rd_en is asserted.
module rom_entry_walker
    import rom_walk_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int START_POS = 22,
    parameter int PORT_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rom_size,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              rec_valid,
    output logic [IDX_W-1:0]  rec_port,
    output logic              rec_disabled,
    output logic              rec_link,
    output logic              rec_has_dual,
    output logic [IDX_W-1:0]  rec_dual_port,
    output logic              walk_done,
    output logic              walk_err,
    output logic [1:0]        err_code
);
    localparam logic [ADDR_W-1:0] FIRST_POS = ADDR_W'(START_POS);
    localparam logic [7:0]        PLEN      = 8'(PORT_LEN);

    walk_state_t       state;
    logic [ADDR_W-1:0] pos;
    logic [ADDR_W-1:0] size_q;
    logic [7:0]        len_q;
    logic [7:0]        hdr_q;
    logic [7:0]        link_q;
    logic [7:0]        hdr_mux;
    logic              overrun;
    logic              is_port;
    port_rec_t         dec_rec;
    port_rec_t         rec_q;
    logic [ADDR_W-1:0] pos_next;

    entry_guard #(.ADDR_W(ADDR_W)) guard_i (
        .pos     (pos),
        .size    (size_q),
        .len     (rd_data),
        .overrun (overrun)
    );

    port_field_decode decode_i (
        .hdr_byte  (hdr_mux),
        .link_byte (link_q),
        .peer_byte (rd_data),
        .is_port   (is_port),
        .rec       (dec_rec)
    );

    // Header byte is live from the port in ST_HDR, held afterwards.
    always_comb hdr_mux = (state == ST_HDR) ? rd_data : hdr_q;

    // Position of the following entry.
    always_comb pos_next = pos + ADDR_W'(len_q);

    // Read request for the byte each state needs next.
    always_comb begin
        rd_en   = 1'b0;
        rd_addr = pos;
        unique case (state)
            ST_CHECK: begin
                rd_en   = (pos < size_q);
                rd_addr = pos;
            end
            ST_LEN: begin
                rd_en   = !overrun;
                rd_addr = pos + ADDR_W'(1);
            end
            ST_HDR: begin
                rd_en   = is_port && !rd_data[6] && (len_q == PLEN);
                rd_addr = pos + ADDR_W'(2);
            end
            ST_LINK: begin
                rd_en   = 1'b1;
                rd_addr = pos + ADDR_W'(3);
            end
            default: ;
        endcase
    end

    // Walk sequencer: position, captured bytes and end/record pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pos       <= '0;
            size_q    <= '0;
            len_q     <= '0;
            hdr_q     <= '0;
            link_q    <= '0;
            rec_q     <= '0;
            rec_valid <= 1'b0;
            walk_done <= 1'b0;
            walk_err  <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            rec_valid <= 1'b0;
            walk_done <= 1'b0;
            walk_err  <= 1'b0;
            err_code  <= ERR_NONE;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        size_q <= rom_size;
                        pos    <= FIRST_POS;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (pos >= size_q) begin
                        walk_done <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        state <= ST_LEN;
                    end
                end
                ST_LEN: begin
                    len_q <= rd_data;
                    if (overrun) begin
                        walk_err <= 1'b1;
                        err_code <= ERR_OVERRUN;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    hdr_q <= rd_data;
                    if (!is_port) begin
                        pos   <= pos_next;
                        state <= ST_CHECK;
                    end else if (dec_rec.disabled) begin
                        rec_q     <= dec_rec;
                        rec_valid <= 1'b1;
                        pos       <= pos_next;
                        state     <= ST_CHECK;
                    end else if (len_q != PLEN) begin
                        walk_err <= 1'b1;
                        err_code <= ERR_LENGTH;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_LINK;
                    end
                end
                ST_LINK: begin
                    link_q <= rd_data;
                    state  <= ST_PEER;
                end
                ST_PEER: begin
                    rec_q     <= dec_rec;
                    rec_valid <= 1'b1;
                    pos       <= pos_next;
                    state     <= ST_CHECK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state != ST_IDLE);
    assign rec_port      = rec_q.port;
    assign rec_disabled  = rec_q.disabled;
    assign rec_link      = rec_q.link;
    assign rec_has_dual  = rec_q.has_dual;
    assign rec_dual_port = rec_q.dual_port;
endmodule

// File: rtl/rom_entry_walker_chk.sv
// Protocol checker for rom_entry_walker, attached by bind below.
// Assumes it sees the top-level ports plus the captured size.
module rom_entry_walker_chk #(
    parameter int ADDR_W    = 11,
    parameter int START_POS = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] size_q,
    input logic              rec_valid,
    input logic              walk_done,
    input logic              walk_err,
    input logic [1:0]        err_code
);
    AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!rd_en || rd_addr == ADDR_W'(START_POS))); // R2
    AST_READ_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < size_q)); // R9
    AST_ERR_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err |-> (err_code == 2'd1 || err_code == 2'd2)); // R7
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_done && walk_err)); // R11
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done || walk_err) |-> !busy); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done); // R11
    AST_REC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid); // R11
    AST_REC_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> busy); // R11
endmodule

bind rom_entry_walker rom_entry_walker_chk #(
    .ADDR_W    (ADDR_W),
    .START_POS (START_POS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .size_q    (size_q),
    .rec_valid (rec_valid),
    .walk_done (walk_done),
    .walk_err  (walk_err),
    .err_code  (err_code)
);

// File: tb/rom_entry_walker_tb_top.sv
module rom_entry_walker_tb_top;
    import rom_walk_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] rom_size = '0;
    logic        rd_en;
    logic [10:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        busy, rec_valid, rec_disabled, rec_link, rec_has_dual;
    logic [5:0]  rec_port, rec_dual_port;
    logic        walk_done, walk_err;
    logic [1:0]  err_code;

    logic [7:0]  rom [0:2047];
    port_rec_t   exp_q[$];
    int          cur;
    int          n_checks = 0;
    int          n_fail = 0;
    int          end_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_entry_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rom_size(rom_size),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .rec_valid(rec_valid), .rec_port(rec_port), .rec_disabled(rec_disabled),
        .rec_link(rec_link), .rec_has_dual(rec_has_dual),
        .rec_dual_port(rec_dual_port), .walk_done(walk_done),
        .walk_err(walk_err), .err_code(err_code)
    );

    // ROM model with one cycle of read latency.
    always @(posedge clk) if (rd_en) rd_data <= rom[rd_addr];

    task automatic check(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Monitor: pops expected records and counts end pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rec_valid) begin
                port_rec_t got;
                got = '{rec_port, rec_disabled, rec_link, rec_has_dual, rec_dual_port};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", $sformatf("unexpected record act=%h exp=none", got));
                end else begin
                    port_rec_t e;
                    e = exp_q.pop_front();
                    check(got == e, e.disabled ? "R5" : "R6",
                          $sformatf("record act=%h exp=%h", got, e));
                end
            end
            if (walk_done || walk_err) end_cnt++;
        end
    end

    task automatic clear_rom();
        for (int i = 0; i < 2048; i++) rom[i] = 8'h00;
        cur = 22;
        exp_q.delete();
    endtask

    task automatic put_generic(input int len);
        rom[cur] = 8'(len);
        rom[cur+1] = 8'h15;
        for (int i = 2; i < len; i++) rom[cur+i] = 8'h9C;
        cur += len;
    endtask

    task automatic put_disabled(input logic [5:0] idx, input int len);
        rom[cur] = 8'(len);
        rom[cur+1] = {2'b11, idx};
        for (int i = 2; i < len; i++) rom[cur+i] = 8'hFF;
        exp_q.push_back('{idx, 1'b1, 1'b0, 1'b0, 6'd0});
        cur += len;
    endtask

    task automatic put_port(input logic [5:0] idx, input bit link,
                            input bit hasd, input logic [5:0] dual);
        rom[cur] = 8'd8;
        rom[cur+1] = {2'b10, idx};
        rom[cur+2] = {hasd, 2'b11, link, 4'h5};
        rom[cur+3] = {2'b11, dual};
        for (int i = 4; i < 8; i++) rom[cur+i] = 8'hC3;
        exp_q.push_back('{idx, 1'b0, link, hasd, hasd ? dual : 6'd0});
        cur += 8;
    endtask

    // Driver: starts a walk and checks its end against the expectation.
    task automatic run_walk(input int size, input bit exp_err,
                            input logic [1:0] exp_code, input string req,
                            input bit restart);
        int waited;
        end_cnt = 0;
        @(negedge clk);
        rom_size = 11'(size);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (size > 22)
            check(rd_en && rd_addr == 11'd22, "R2",
                  $sformatf("first read en=%0b addr=%0d exp en=1 addr=22", rd_en, rd_addr));
        waited = 0;
        while (!(walk_done || walk_err) && waited < 500) begin
            if (restart && waited == 2) begin
                start = 1'b1;
                rom_size = 11'd0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        check(walk_err == exp_err && walk_done == !exp_err && !busy, req,
              $sformatf("end done=%0b err=%0b busy=%0b exp done=%0b err=%0b busy=0",
                        walk_done, walk_err, busy, !exp_err, exp_err));
        if (exp_err)
            check(err_code == exp_code, req,
                  $sformatf("err_code act=%0d exp=%0d", err_code, exp_code));
        repeat (3) @(negedge clk);
        check(end_cnt == 1, "R11", $sformatf("end pulses act=%0d exp=1", end_cnt));
        check(exp_q.size() == 0, req,
              $sformatf("records missing act=%0d exp=0", exp_q.size()));
        check(!walk_done && !walk_err && !busy, "R11",
              $sformatf("after end done=%0b err=%0b busy=%0b exp 0", walk_done, walk_err, busy));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_rom();
        repeat (3) @(negedge clk);
        check(!busy && !rec_valid && !walk_done && !walk_err, "R1",
              $sformatf("reset busy=%0b rec=%0b done=%0b err=%0b exp 0",
                        busy, rec_valid, walk_done, walk_err));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !rec_valid && !walk_done && !walk_err, "R1",
              $sformatf("idle busy=%0b exp 0", busy));

        // R3: size not beyond the header, no entries walked.
        clear_rom();
        run_walk(20, 1'b0, 2'd0, "R3", 1'b0);

        // R3 R4 R5 R6: mixed valid chain.
        clear_rom();
        put_generic(3);
        put_port(6'd5, 1'b1, 1'b1, 6'd6);
        put_disabled(6'd9, 4);
        put_port(6'd6, 1'b0, 1'b0, 6'h3F);
        put_generic(5);
        run_walk(cur, 1'b0, 2'd0, "R3", 1'b0);

        // R7: zero length after a valid record.
        clear_rom();
        put_port(6'd2, 1'b0, 1'b1, 6'd1);
        rom[cur] = 8'd0;
        run_walk(40, 1'b1, 2'd1, "R7", 1'b0);

        // R8: entry starting at the last byte.
        clear_rom();
        put_generic(2);
        rom[cur] = 8'd1;
        rom[cur+1] = 8'h00;
        run_walk(cur + 1, 1'b1, 2'd1, "R8", 1'b0);

        // R9: entry running past the end.
        clear_rom();
        rom[22] = 8'd10;
        run_walk(30, 1'b1, 2'd1, "R9", 1'b0);

        // R10: enabled port with wrong length.
        clear_rom();
        rom[22] = 8'd6;
        rom[23] = 8'h83;
        run_walk(40, 1'b1, 2'd2, "R10", 1'b0);

        // R12: start and size change while busy are ignored.
        clear_rom();
        put_port(6'd11, 1'b1, 1'b0, 6'd0);
        put_disabled(6'd12, 2);
        run_walk(cur, 1'b0, 2'd0, "R12", 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule